// File: doc/BRIEF.md
# Transfer Segmenter for Page-Limited Descriptors

This block splits a transfer request into a stream of descriptor chunks. A request gives a start byte address, a total byte count, a maximum packet size and a single-transaction flag. Each chunk comes out with its start address, its byte length, the number of bus transactions it holds and the size of its final transaction. A host controller's descriptor writer uses these values to fill one descriptor per chunk.

A descriptor may cover at most `PAGES` pages of 0x1000 bytes. `PAGES` is 2 for the compact format and 5 for the wide format. The room in a chunk therefore depends on where it starts inside its first page. Every chunk other than the last is cut back to a whole number of maximum-size packets, so the device still sees one unbroken transfer. In single-transaction mode each chunk holds exactly one packet.

Requests enter on a valid/ready port, and chunks leave on a valid/ready stream. A one-cycle `done` pulse marks the end of a transfer. The next request is taken no earlier than that pulse.

Top module: `xfer_segmenter`

## Requirements
- R1: Let the offset be address bits [11:0] of a chunk. The offset plus the chunk length never exceeds `PAGES`*0x1000. With `PAGES`=2, a page-aligned start allows 0x2000 bytes and an offset of 0xFFF allows 0x1001. With `PAGES`=5, an offset of 0xFFF allows 0x4001.
- R2: The first chunk starts at the request address. Each later chunk starts at the previous chunk's address plus its length, modulo 2^`ADDR_W`. The chunk lengths add up to the request length.
- R3: Outside single mode, a chunk that is not final has length (`PAGES`*0x1000 − offset) rounded down to a multiple of the maximum packet size. The maximum packet size must be between 1 and 0x1000.
- R4: When the bytes left fit in the capacity, they go out as one chunk with `out_last`=1. No other chunk has `out_last`=1.
- R5: For a chunk of nonzero length L and packet size M, `out_xact_cnt` is ceil(L/M) and `out_tail_len` is L − (cnt−1)·M, which lies in 1..M.
- R6: In single-transaction mode each chunk has length min(bytes left, M) and `out_xact_cnt`=1. The chunk is final when the bytes left are at most M.
- R7: A zero-length request yields exactly one chunk with length 0, `out_xact_cnt`=1, `out_tail_len`=0 and `out_last`=1.
- R8: `done` is high for exactly the one cycle after the final chunk's handshake. `req_ready` is high in that same cycle. `req_ready` stays low from request acceptance until then.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all chunk fields hold steady.
- R10: After reset, `req_ready`=1, `out_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Segmenter idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total byte count |
| req_mps | input | MPS_W | Maximum packet size in bytes |
| req_single | input | 1 | One transaction per chunk |
| out_valid | output | 1 | Chunk offered |
| out_ready | input | 1 | Consumer takes the chunk |
| out_addr | output | ADDR_W | Chunk start address |
| out_len | output | CAP_W | Chunk byte length |
| out_xact_cnt | output | CAP_W | Transactions in the chunk |
| out_tail_len | output | MPS_W | Size of the chunk's final transaction |
| out_last | output | 1 | Chunk ends the transfer |
| done | output | 1 | Transfer completion pulse |

## Verification
Two events can fall in the same cycle: the `done` pulse that closes one transfer, and the acceptance of the next request. The bench provokes this by holding the next request ready and offering it the moment `req_ready` rises. It then checks that `done` and `req_ready` are both high in that cycle. It also checks that the new transfer's first chunk starts at the new address and not at the old one. Two instances, one for each descriptor format, run the same requests under independent random back-pressure. Each chunk is compared against a model computed in the bench.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int PAGE_BITS  = 12;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SPAN = 2'd1,
    ST_DIV  = 2'd2,
    ST_EMIT = 2'd3
  } seg_state_t;
endpackage

// File: rtl/seg_span.sv
module seg_span #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 11,
  parameter int CAP_W = 14,
  parameter int PAGES = 2
) (
  input  logic [seg_pkg::PAGE_BITS-1:0] offset,
  input  logic [LEN_W-1:0]              rem,
  input  logic [MPS_W-1:0]              mps,
  input  logic                          single,
  output logic [CAP_W-1:0]              span,
  output logic                          is_final
);
  localparam int CMP_W     = (LEN_W > CAP_W) ? LEN_W : CAP_W;
  localparam int CAP_BYTES = PAGES * seg_pkg::PAGE_BYTES;

  logic [CMP_W-1:0] cap_x, rem_x, mps_x;

  assign cap_x = CMP_W'(CAP_BYTES) - CMP_W'(offset);
  assign rem_x = CMP_W'(rem);
  assign mps_x = CMP_W'(mps);

  always_comb begin
    if (single) begin
      is_final = (rem_x <= mps_x);
      span     = is_final ? CAP_W'(rem_x) : CAP_W'(mps_x);
    end else begin
      is_final = (rem_x <= cap_x);
      span     = is_final ? CAP_W'(rem_x) : CAP_W'(cap_x);
    end
  end
endmodule

// File: rtl/seg_divider.sv
module seg_divider #(
  parameter int N_W = 14,
  parameter int D_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [N_W-1:0] quot,
  output logic [D_W-1:0] rmd
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [N_W-1:0]   num_q, quot_q;
  logic [D_W-1:0]   part_q, dvs_q;
  logic             busy_q, done_q;
  logic [D_W:0]     trial, diff;
  logic             take;

  assign trial = {part_q, num_q[N_W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign take  = (trial >= {1'b0, dvs_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      num_q  <= '0;
      quot_q <= '0;
      part_q <= '0;
      dvs_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        num_q  <= dividend;
        dvs_q  <= divisor;
        part_q <= '0;
        quot_q <= '0;
        cnt_q  <= CNT_W'(N_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        part_q <= take ? D_W'(diff) : D_W'(trial);
        quot_q <= {quot_q[N_W-2:0], take};
        num_q  <= num_q << 1;
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quot = quot_q;
  assign rmd  = part_q;

  AST_DIV_RMD_BOUND: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (part_q < dvs_q)); // R5
endmodule

// File: rtl/seg_xact_fmt.sv
module seg_xact_fmt #(
  parameter int MPS_W = 11,
  parameter int CAP_W = 14
) (
  input  logic [CAP_W-1:0] span,
  input  logic [CAP_W-1:0] quot,
  input  logic [MPS_W-1:0] rmd,
  input  logic [MPS_W-1:0] mps,
  input  logic             is_final,
  input  logic             single,
  output logic [CAP_W-1:0] len,
  output logic [CAP_W-1:0] cnt,
  output logic [MPS_W-1:0] tail
);
  always_comb begin
    if (single) begin
      len  = span;
      cnt  = CAP_W'(1);
      tail = MPS_W'(span);
    end else if (is_final) begin
      len = span;
      if (span == '0) begin
        cnt  = CAP_W'(1);
        tail = '0;
      end else if (rmd != '0) begin
        cnt  = quot + CAP_W'(1);
        tail = rmd;
      end else begin
        cnt  = quot;
        tail = mps;
      end
    end else begin
      len  = span - CAP_W'(rmd);
      cnt  = quot;
      tail = mps;
    end
  end
endmodule

// File: rtl/xfer_segmenter.sv
module xfer_segmenter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int MPS_W  = 11,
  parameter int PAGES  = 2,
  parameter int CAP_W  = $clog2(PAGES * seg_pkg::PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [MPS_W-1:0]  req_mps,
  input  logic              req_single,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CAP_W-1:0]  out_len,
  output logic [CAP_W-1:0]  out_xact_cnt,
  output logic [MPS_W-1:0]  out_tail_len,
  output logic              out_last,
  output logic              done
);
  import seg_pkg::*;

  localparam int CAP_BYTES = PAGES * PAGE_BYTES;

  seg_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [MPS_W-1:0]  mps_q;
  logic              single_q;
  logic [CAP_W-1:0]  span_q;
  logic              final_q;
  logic              done_q;

  logic [ADDR_W-1:0] o_addr_q;
  logic [CAP_W-1:0]  o_len_q, o_cnt_q;
  logic [MPS_W-1:0]  o_tail_q;
  logic              o_last_q;

  logic [CAP_W-1:0]  span_c;
  logic              final_c;
  logic              div_start, div_done;
  logic [CAP_W-1:0]  div_quot;
  logic [MPS_W-1:0]  div_rmd;
  logic [CAP_W-1:0]  fmt_len, fmt_cnt;
  logic [MPS_W-1:0]  fmt_tail;

  seg_span #(.LEN_W(LEN_W), .MPS_W(MPS_W), .CAP_W(CAP_W), .PAGES(PAGES)) u_span (
    .offset   (addr_q[PAGE_BITS-1:0]),
    .rem      (rem_q),
    .mps      (mps_q),
    .single   (single_q),
    .span     (span_c),
    .is_final (final_c)
  );

  assign div_start = (state_q == ST_SPAN) && !single_q;

  seg_divider #(.N_W(CAP_W), .D_W(MPS_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (span_c),
    .divisor  (mps_q),
    .done     (div_done),
    .quot     (div_quot),
    .rmd      (div_rmd)
  );

  seg_xact_fmt #(.MPS_W(MPS_W), .CAP_W(CAP_W)) u_fmt (
    .span     (span_q),
    .quot     (div_quot),
    .rmd      (div_rmd),
    .mps      (mps_q),
    .is_final (final_q),
    .single   (single_q),
    .len      (fmt_len),
    .cnt      (fmt_cnt),
    .tail     (fmt_tail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      mps_q    <= '0;
      single_q <= 1'b0;
      span_q   <= '0;
      final_q  <= 1'b0;
      done_q   <= 1'b0;
      o_addr_q <= '0;
      o_len_q  <= '0;
      o_cnt_q  <= '0;
      o_tail_q <= '0;
      o_last_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q   <= req_addr;
            rem_q    <= req_len;
            mps_q    <= req_mps;
            single_q <= req_single;
            state_q  <= ST_SPAN;
          end
        end
        ST_SPAN: begin
          span_q  <= span_c;
          final_q <= final_c;
          state_q <= ST_DIV;
        end
        ST_DIV: begin
          if (single_q || div_done) begin
            o_addr_q <= addr_q;
            o_len_q  <= fmt_len;
            o_cnt_q  <= fmt_cnt;
            o_tail_q <= fmt_tail;
            o_last_q <= final_q;
            state_q  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            addr_q <= addr_q + ADDR_W'(o_len_q);
            rem_q  <= rem_q - LEN_W'(o_len_q);
            if (o_last_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_SPAN;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign out_valid    = (state_q == ST_EMIT);
  assign out_addr     = o_addr_q;
  assign out_len      = o_len_q;
  assign out_xact_cnt = o_cnt_q;
  assign out_tail_len = o_tail_q;
  assign out_last     = o_last_q;
  assign done         = done_q;

  AST_SPAN_FITS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (32'(out_addr[PAGE_BITS-1:0]) + 32'(out_len) <= 32'(CAP_BYTES))); // R1
  AST_NONFINAL_MULT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last && !single_q) |-> (32'(out_len) == 32'(out_xact_cnt) * 32'(mps_q))); // R3
  AST_TAIL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len != '0) |-> (out_tail_len != '0 && out_tail_len <= mps_q)); // R5
  AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && single_q) |-> (out_xact_cnt == CAP_W'(1))); // R6
  AST_ZERO_CHUNK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == '0) |-> (out_last && out_xact_cnt == CAP_W'(1) && out_tail_len == '0)); // R7
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(out_valid && out_ready && out_last) && req_ready)); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)
      && $stable(out_xact_cnt) && $stable(out_tail_len) && $stable(out_last))); // R9
endmodule

// File: tb/xfer_segmenter_tb.sv
`timescale 1ns/1ps
module xfer_segmenter_mon #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int MPS_W  = 11,
  parameter int CAP_W  = 14,
  parameter int PAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [MPS_W-1:0]  req_mps,
  input  logic              req_single,
  input  logic              out_valid,
  input  logic              out_ready,
  input  logic [ADDR_W-1:0] out_addr,
  input  logic [CAP_W-1:0]  out_len,
  input  logic [CAP_W-1:0]  out_cnt,
  input  logic [MPS_W-1:0]  out_tail,
  input  logic              out_last,
  input  logic              done,
  output int                chk,
  output int                err,
  output logic              busy,
  output int                first_len
);
  logic [ADDR_W-1:0] m_addr;
  int  m_rem, m_mps, m_nchunk;
  bit  m_single, pend_done, stall;
  logic [ADDR_W-1:0] p_addr;
  logic [CAP_W-1:0]  p_len, p_cnt;
  logic [MPS_W-1:0]  p_tail;
  logic              p_last;

  initial begin
    chk = 0; err = 0; busy = 1'b0; first_len = -1;
    pend_done = 0; stall = 0; m_nchunk = 0;
  end

  task automatic judge(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s pages=%0d %s: actual=0x%0h expected=0x%0h", tag, PAGES, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (done || pend_done) begin
        judge(done == pend_done, "R8", "done pulse", done, pend_done);
        if (pend_done) judge(req_ready, "R8", "req_ready with done", req_ready, 1);
      end
      pend_done = 0;
      if (stall) begin
        judge(out_valid && out_addr == p_addr && out_len == p_len && out_cnt == p_cnt
              && out_tail == p_tail && out_last == p_last, "R9", "held chunk len", out_len, p_len);
      end
      if (req_valid && req_ready) begin
        m_addr = req_addr; m_rem = int'(req_len); m_mps = int'(req_mps);
        m_single = req_single; busy = 1'b1; m_nchunk = 0;
      end
      if (out_valid && out_ready) begin
        int cap, elen, ecnt, etail, off;
        bit elast;
        string tag;
        off = int'(m_addr[11:0]);
        cap = PAGES * 4096 - off;
        if (m_single) begin
          elast = (m_rem <= m_mps);
          elen  = elast ? m_rem : m_mps;
        end else begin
          elast = (m_rem <= cap);
          elen  = elast ? m_rem : cap - (cap % m_mps);
        end
        ecnt  = (elen == 0) ? 1 : (elen + m_mps - 1) / m_mps;
        etail = (elen == 0) ? 0 : elen - (ecnt - 1) * m_mps;
        if (m_rem == 0) tag = "R7";
        else if (m_single) tag = "R6";
        else if (elast) tag = "R4";
        else tag = "R3";
        judge(out_addr == m_addr, "R2", "chunk address", out_addr, m_addr);
        judge(int'(out_len) == elen && out_last == elast, tag, "chunk length", out_len, elen);
        judge(int'(out_cnt) == ecnt && int'(out_tail) == etail, "R5", "xact count/tail",
              {out_cnt, out_tail}, {ecnt[CAP_W-1:0], etail[MPS_W-1:0]});
        judge(int'(out_addr[11:0]) + int'(out_len) <= PAGES * 4096, "R1", "page window",
              int'(out_addr[11:0]) + int'(out_len), PAGES * 4096);
        if (m_nchunk == 0) first_len = int'(out_len);
        m_nchunk++;
        m_addr = m_addr + ADDR_W'(elen);
        m_rem  = m_rem - elen;
        if (elast) begin
          pend_done = 1;
          busy = 1'b0;
        end
      end
      stall  = out_valid && !out_ready;
      p_addr = out_addr; p_len = out_len; p_cnt = out_cnt; p_tail = out_tail; p_last = out_last;
    end
  end
endmodule

module xfer_segmenter_tb;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int MPS_W  = 11;
  localparam int CAP2_W = $clog2(2 * 4096 + 1);
  localparam int CAP5_W = $clog2(5 * 4096 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [MPS_W-1:0]  req_mps = 11'd64;
  logic              req_single = 1'b0;
  logic              rdy2 = 1'b1, rdy5 = 1'b1;
  bit                random_ready = 1'b0;

  logic              rr2, ov2, ol2, dn2, rr5, ov5, ol5, dn5;
  logic [ADDR_W-1:0] oa2, oa5;
  logic [CAP2_W-1:0] olen2, ocnt2;
  logic [CAP5_W-1:0] olen5, ocnt5;
  logic [MPS_W-1:0]  ot2, ot5;

  int chk2, err2, chk5, err5, fl2, fl5;
  logic busy2, busy5;
  int checks = 0, errors = 0;
  bit finished = 0;

  xfer_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .PAGES(2)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr2), .req_addr(req_addr),
    .req_len(req_len), .req_mps(req_mps), .req_single(req_single), .out_valid(ov2),
    .out_ready(rdy2), .out_addr(oa2), .out_len(olen2), .out_xact_cnt(ocnt2),
    .out_tail_len(ot2), .out_last(ol2), .done(dn2));

  xfer_segmenter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .PAGES(5)) u_dut5 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr5), .req_addr(req_addr),
    .req_len(req_len), .req_mps(req_mps), .req_single(req_single), .out_valid(ov5),
    .out_ready(rdy5), .out_addr(oa5), .out_len(olen5), .out_xact_cnt(ocnt5),
    .out_tail_len(ot5), .out_last(ol5), .done(dn5));

  xfer_segmenter_mon #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .CAP_W(CAP2_W), .PAGES(2)) u_mon2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr2), .req_addr(req_addr),
    .req_len(req_len), .req_mps(req_mps), .req_single(req_single), .out_valid(ov2),
    .out_ready(rdy2), .out_addr(oa2), .out_len(olen2), .out_cnt(ocnt2), .out_tail(ot2),
    .out_last(ol2), .done(dn2), .chk(chk2), .err(err2), .busy(busy2), .first_len(fl2));

  xfer_segmenter_mon #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .CAP_W(CAP5_W), .PAGES(5)) u_mon5 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr5), .req_addr(req_addr),
    .req_len(req_len), .req_mps(req_mps), .req_single(req_single), .out_valid(ov5),
    .out_ready(rdy5), .out_addr(oa5), .out_len(olen5), .out_cnt(ocnt5), .out_tail(ot5),
    .out_last(ol5), .done(dn5), .chk(chk5), .err(err5), .busy(busy5), .first_len(fl5));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (random_ready) begin
      rdy2 = ($urandom % 4) != 0;
      rdy5 = ($urandom % 3) != 0;
    end else begin
      rdy2 = 1'b1;
      rdy5 = 1'b1;
    end
  end

  task automatic send(input logic [ADDR_W-1:0] a, input int len, input int mps, input bit single);
    while (!(rr2 && rr5)) begin @(posedge clk); #1; end
    req_addr = a; req_len = LEN_W'(len); req_mps = MPS_W'(mps); req_single = single;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (!(rr2 && rr5) || busy2 || busy5);
  endtask

  initial begin
    void'($urandom(32'h5EED_0001));
    repeat (3) @(posedge clk);
    #1;
    check(rr2 && rr5 && !ov2 && !ov5 && !dn2 && !dn5, "R10", "state during reset",
          {rr2, rr5, ov2, ov5, dn2, dn5}, 6'b110000);
    rst = 1'b0;
    @(posedge clk); #1;
    check(rr2 && !ov2 && !dn2, "R10", "state after reset", {rr2, ov2, dn2}, 3'b100);

    send(32'h0001_0000, 16'h3000, 512, 0); wait_idle();
    check(fl2 == 'h2000, "R1", "aligned first chunk, 2 pages", fl2, 'h2000);
    send(32'h0002_0FFF, 16'h6000, 1, 0); wait_idle();
    check(fl2 == 'h1001, "R1", "offset 0xFFF first chunk, 2 pages", fl2, 'h1001);
    check(fl5 == 'h4001, "R1", "offset 0xFFF first chunk, 5 pages", fl5, 'h4001);
    send(32'h0003_0FFF, 16'h5000, 64, 0); wait_idle();
    check(fl2 == 'h1000, "R3", "trimmed first chunk, mps 64", fl2, 'h1000);
    send(32'h0004_0123, 0, 8, 0); wait_idle();
    check(fl2 == 0 && fl5 == 0, "R7", "zero-length chunk", fl2, 0);
    send(32'h0005_0F00, 16'h0A00, 1024, 1); wait_idle();
    check(fl2 == 1024, "R6", "single-mode first chunk", fl2, 1024);

    random_ready = 1'b1;
    send(32'h0006_0010, 16'h1234, 1023, 0); wait_idle();
    send(32'hFFFF_F800, 16'h2345, 512, 0); wait_idle();
    for (int i = 0; i < 60; i++) begin
      logic [ADDR_W-1:0] a;
      int len, mps;
      bit single;
      a = $urandom;
      single = ($urandom % 6) == 0;
      if (single) begin
        mps = 256 + int'($urandom % 769);
        len = int'($urandom % 'h2000);
      end else begin
        mps = 1 + int'($urandom % 1024);
        len = ($urandom % 10 == 0) ? 0 : int'($urandom % 'h6000);
      end
      send(a, len, mps, single);
    end
    wait_idle();
    repeat (4) @(posedge clk);
    finished = 1;
    checks = checks + chk2 + chk5;
    errors = errors + err2 + err5;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks = checks + chk2 + chk5 + 1;
      errors = errors + err2 + err5 + 1;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule